// File: doc/BRIEF.md
# Parallel-Chain Scan Self-Test Sequencer

This block runs a logic self-test over a set of parallel scan chains. One linear feedback shift register produces the stimulus. An XOR spreading network sits between that register and the chain inputs, so each chain receives its own decorrelated bit stream rather than a delayed copy of its neighbour's. The chain outputs are folded into a multiple-input signature register that has one stage per chain.

Each pattern has three parts. First the chains are filled by shifting for one full chain length. Then scan-enable is dropped for a single functional capture clock. The captured responses are shifted out while the next pattern shifts in. After the last capture, one extra unload-only pass pushes the final responses into the signature. The controller then raises done and holds the signature until the next start.

Top module: `scan_bist_ctrl`

## Requirements
- R1: After reset, scan_en, capture_en and done are 0 and signature is all zeros.
- R2: After an accepted start with a nonzero pattern total T, each pattern gives CHAIN_LEN cycles with scan_en=1, capture_en=0, followed by exactly one cycle with scan_en=0, capture_en=1. The two enables are never high together.
- R3: In every fill cycle, chain_si[c] equals bit (c mod LFSR_W) XOR bit ((5c+3) mod LFSR_W) of the generator state. The generator is seeded with LFSR_SEED when start is accepted. It steps once per fill cycle as a left shift whose new bit 0 is the XOR of the state bits selected by LFSR_POLY.
- R4: In each shift cycle that follows at least one capture, the signature register updates as sig' = (sig<<1) ^ (sig[MSB] ? MISR_POLY : 0) ^ chain_so. It is set to MISR_INIT when start is accepted. Shift cycles before the first capture leave it unchanged, as do capture and idle cycles.
- R5: After the T-th capture comes an unload-only pass of CHAIN_LEN cycles with scan_en=1, during which chain_si is all zeros.
- R6: done rises exactly T*(CHAIN_LEN+1)+CHAIN_LEN cycles after the first cycle following the start edge.
- R7: While done is high and start is low, done stays high and signature does not change, whatever pat_total does.
- R8: A start pulse while a run is in progress is ignored: timing and signature are the same as if no pulse had occurred.
- R9: A start with pat_total = 0 raises done on the next cycle with signature = MISR_INIT, and no shifting takes place.
- R10: pat_total is sampled only when start is accepted. Changing it during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; accepted only when idle or done |
| pat_total | input | PAT_W | Number of patterns to apply |
| scan_en | output | 1 | Chains shift when high |
| capture_en | output | 1 | One-cycle functional capture strobe |
| chain_si | output | NUM_CHAINS | Serial input for each chain |
| chain_so | input | NUM_CHAINS | Serial output from each chain |
| done | output | 1 | Run complete, signature valid |
| signature | output | NUM_CHAINS | Signature register contents |

## Verification
The assertions check on every cycle that the two enables are mutually exclusive and that each capture is a one-cycle strobe directly after a shift. They also check that the unload-only pass never captures, that the signature moves only on compaction cycles or at seeding, that a held done freezes the signature, and that a start during a run leaves the latched total untouched. The exact cycle of done, the spreading-network values on every fill cycle, and the final signature depend on the whole run. Only the bench scenarios show these: a software model of the chains, generator and compactor is run for the zero-total, single-pattern and random-total cases, with mid-run start pulses and total changes mixed in.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_CAPT  = 3'd2,
    ST_FLUSH = 3'd3,
    ST_DONE  = 3'd4
  } bist_state_e;
endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen #(
  parameter int                NUM_CHAINS = 25,
  parameter int                LFSR_W     = 32,
  parameter logic [LFSR_W-1:0] LFSR_POLY  = 32'h8020_0003,
  parameter logic [LFSR_W-1:0] LFSR_SEED  = 32'h1D87_2B41
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seed_load,
  input  logic                  advance,
  output logic [NUM_CHAINS-1:0] spread_out
);
  logic [LFSR_W-1:0] gen_q;

  function automatic logic [LFSR_W-1:0] gen_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & LFSR_POLY)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gen_q <= LFSR_SEED;
    else if (seed_load) gen_q <= LFSR_SEED;
    else if (advance)   gen_q <= gen_step(gen_q);
  end

  // XOR spreading network: two distinct taps per chain
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_spread
    localparam int TAP_A = c % LFSR_W;
    localparam int TAP_B = (5 * c + 3) % LFSR_W;
    assign spread_out[c] = gen_q[TAP_A] ^ gen_q[TAP_B];
  end
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int                    WIDTH     = 25,
  parameter logic [WIDTH-1:0]      POLY      = WIDTH'(9),
  parameter logic [WIDTH-1:0]      INIT      = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic             compact,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] sig
);
  function automatic logic [WIDTH-1:0] fold(input logic [WIDTH-1:0] s,
                                            input logic [WIDTH-1:0] d);
    return {s[WIDTH-2:0], 1'b0} ^ (s[WIDTH-1] ? POLY : '0) ^ d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sig <= '0;
    else if (seed_load) sig <= INIT;
    else if (compact)   sig <= fold(sig, data_in);
  end
endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer
  import bist_pkg::*;
#(
  parameter int CHAIN_LEN = 200,
  parameter int PAT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAT_W-1:0] pat_total,
  output logic             scan_en,
  output logic             capture_en,
  output logic             done,
  output logic             seed_load,
  output logic             gen_advance,
  output logic             compact_en,
  output logic             flush_active,
  output logic             busy,
  output logic [PAT_W-1:0] total_latched
);
  localparam int CNT_W = $clog2(CHAIN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(CHAIN_LEN - 1);

  bist_state_e       state_q;
  logic [CNT_W-1:0]  shift_q;
  logic [PAT_W-1:0]  pat_q;
  logic [PAT_W-1:0]  pat_next;
  logic              have_resp_q;
  logic              shift_last;

  assign shift_last = (shift_q == LAST_SHIFT);
  assign pat_next   = pat_q + 1'b1;
  assign busy       = (state_q == ST_LOAD) || (state_q == ST_CAPT) || (state_q == ST_FLUSH);
  assign seed_load  = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      shift_q       <= '0;
      pat_q         <= '0;
      have_resp_q   <= 1'b0;
      total_latched <= '0;
    end else if (seed_load) begin
      total_latched <= pat_total;
      shift_q       <= '0;
      pat_q         <= '0;
      have_resp_q   <= 1'b0;
      state_q       <= (pat_total == '0) ? ST_DONE : ST_LOAD;
    end else begin
      unique case (state_q)
        ST_LOAD: begin
          shift_q <= shift_last ? '0 : shift_q + 1'b1;
          if (shift_last) state_q <= ST_CAPT;
        end
        ST_CAPT: begin
          pat_q       <= pat_next;
          have_resp_q <= 1'b1;
          state_q     <= (pat_next == total_latched) ? ST_FLUSH : ST_LOAD;
        end
        ST_FLUSH: begin
          shift_q <= shift_last ? '0 : shift_q + 1'b1;
          if (shift_last) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign scan_en      = (state_q == ST_LOAD) || (state_q == ST_FLUSH);
  assign capture_en   = (state_q == ST_CAPT);
  assign done         = (state_q == ST_DONE);
  assign flush_active = (state_q == ST_FLUSH);
  assign gen_advance  = (state_q == ST_LOAD);
  assign compact_en   = ((state_q == ST_LOAD) && have_resp_q) || flush_active;
endmodule

// File: rtl/scan_bist_ctrl.sv
module scan_bist_ctrl #(
  parameter int                    NUM_CHAINS = 25,
  parameter int                    CHAIN_LEN  = 200,
  parameter int                    PAT_W      = 16,
  parameter int                    LFSR_W     = 32,
  parameter logic [LFSR_W-1:0]     LFSR_POLY  = 32'h8020_0003,
  parameter logic [LFSR_W-1:0]     LFSR_SEED  = 32'h1D87_2B41,
  parameter logic [NUM_CHAINS-1:0] MISR_POLY  = NUM_CHAINS'(9),
  parameter logic [NUM_CHAINS-1:0] MISR_INIT  = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [PAT_W-1:0]      pat_total,
  output logic                  scan_en,
  output logic                  capture_en,
  output logic [NUM_CHAINS-1:0] chain_si,
  input  logic [NUM_CHAINS-1:0] chain_so,
  output logic                  done,
  output logic [NUM_CHAINS-1:0] signature
);
  logic                  seed_load;
  logic                  gen_advance;
  logic                  compact_en;
  logic                  flush_active;
  logic                  busy;
  logic [PAT_W-1:0]      total_latched;
  logic [NUM_CHAINS-1:0] spread_vec;

  bist_sequencer #(.CHAIN_LEN(CHAIN_LEN), .PAT_W(PAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_total(pat_total),
    .scan_en(scan_en), .capture_en(capture_en), .done(done),
    .seed_load(seed_load), .gen_advance(gen_advance), .compact_en(compact_en),
    .flush_active(flush_active), .busy(busy), .total_latched(total_latched)
  );

  bist_pattern_gen #(
    .NUM_CHAINS(NUM_CHAINS), .LFSR_W(LFSR_W),
    .LFSR_POLY(LFSR_POLY), .LFSR_SEED(LFSR_SEED)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load),
    .advance(gen_advance), .spread_out(spread_vec)
  );

  // unload-only pass shifts zeros in
  assign chain_si = flush_active ? '0 : spread_vec;

  bist_misr #(.WIDTH(NUM_CHAINS), .POLY(MISR_POLY), .INIT(MISR_INIT)) u_misr (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .compact(compact_en),
    .data_in(chain_so), .sig(signature)
  );
endmodule

// File: rtl/scan_bist_ctrl_sva.sv
module scan_bist_ctrl_sva #(
  parameter int NUM_CHAINS = 25,
  parameter int PAT_W      = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  scan_en,
  input logic                  capture_en,
  input logic                  done,
  input logic [NUM_CHAINS-1:0] signature,
  input logic                  busy,
  input logic                  flush_active,
  input logic                  compact_en,
  input logic                  seed_load,
  input logic [PAT_W-1:0]      total_latched
);
  assert_enables_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en && capture_en));

  assert_capture_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> !capture_en);

  assert_capture_after_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |-> $past(scan_en));

  assert_flush_no_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_active |=> !capture_en);

  assert_sig_only_on_compact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!compact_en && !seed_load) |=> $stable(signature));

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(signature)));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(total_latched));
endmodule

bind scan_bist_ctrl scan_bist_ctrl_sva #(.NUM_CHAINS(NUM_CHAINS), .PAT_W(PAT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en),
  .capture_en(capture_en), .done(done), .signature(signature), .busy(busy),
  .flush_active(flush_active), .compact_en(compact_en), .seed_load(seed_load),
  .total_latched(total_latched)
);

// File: tb/scan_bist_ctrl_tb.sv
module scan_bist_ctrl_tb;
  localparam int          NC    = 25;
  localparam int          L     = 200;
  localparam int          PW    = 16;
  localparam int          LW    = 32;
  localparam logic [LW-1:0] LPOLY = 32'h8020_0003;
  localparam logic [LW-1:0] SEED  = 32'h1D87_2B41;
  localparam logic [NC-1:0] MPOLY = NC'(9);
  localparam logic [NC-1:0] MINIT = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [PW-1:0] pat_total = '0;
  logic          scan_en, capture_en, done;
  logic [NC-1:0] chain_si, chain_so, signature;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2ns clk = ~clk;

  scan_bist_ctrl #(
    .NUM_CHAINS(NC), .CHAIN_LEN(L), .PAT_W(PW), .LFSR_W(LW),
    .LFSR_POLY(LPOLY), .LFSR_SEED(SEED), .MISR_POLY(MPOLY), .MISR_INIT(MINIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_total(pat_total),
    .scan_en(scan_en), .capture_en(capture_en), .chain_si(chain_si),
    .chain_so(chain_so), .done(done), .signature(signature)
  );

  // Scan chains with a stand-in capture function
  logic [L-1:0] chn [NC];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) chn[c] <= '0;
    end else if (scan_en) begin
      for (int c = 0; c < NC; c++) chn[c] <= {chn[c][L-2:0], chain_si[c]};
    end else if (capture_en) begin
      for (int c = 0; c < NC; c++)
        chn[c] <= {chn[c][L-2:0], chn[c][L-1]} ^ chn[(c + 1) % NC];
    end
  end
  always_comb for (int c = 0; c < NC; c++) chain_so[c] = chn[c][L-1];

  // Bench restatements of the requirement arithmetic
  function automatic logic [LW-1:0] b_gen(input logic [LW-1:0] s);
    logic fb = 1'b0;
    for (int i = 0; i < LW; i++) if (LPOLY[i]) fb = fb ^ s[i];
    return (s << 1) | LW'(fb);
  endfunction

  function automatic logic [NC-1:0] b_spread(input logic [LW-1:0] s);
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = s[c % LW] ^ s[(5 * c + 3) % LW];
    return v;
  endfunction

  function automatic logic [NC-1:0] b_fold(input logic [NC-1:0] m, input logic [NC-1:0] d);
    logic [NC-1:0] n;
    for (int i = 0; i < NC; i++)
      n[i] = ((i > 0) ? m[i-1] : 1'b0) ^ (m[NC-1] & MPOLY[i]) ^ d[i];
    return n;
  endfunction

  function automatic logic [NC-1:0] model_sig(input int t_pat);
    logic [L-1:0]  ch  [NC];
    logic [L-1:0]  tmp [NC];
    logic [LW-1:0] g = SEED;
    logic [NC-1:0] m = MINIT;
    logic [NC-1:0] outs, ins;
    if (t_pat == 0) return MINIT;
    for (int c = 0; c < NC; c++) ch[c] = '0;
    for (int p = 0; p <= t_pat; p++) begin
      for (int i = 0; i < L; i++) begin
        for (int c = 0; c < NC; c++) outs[c] = ch[c][L-1];
        if (p > 0) m = b_fold(m, outs);
        ins = (p < t_pat) ? b_spread(g) : '0;
        for (int c = 0; c < NC; c++) ch[c] = {ch[c][L-2:0], ins[c]};
        if (p < t_pat) g = b_gen(g);
      end
      if (p < t_pat) begin
        for (int c = 0; c < NC; c++) tmp[c] = {ch[c][L-2:0], ch[c][L-1]} ^ ch[(c + 1) % NC];
        for (int c = 0; c < NC; c++) ch[c] = tmp[c];
      end
    end
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input int t_pat, input bit mid_start, input bit chg_total);
    int P = L + 1;
    int done_t = (t_pat == 0) ? 0 : t_pat * P + L;
    logic [LW-1:0] g = SEED;
    bit bad2 = 0, bad3 = 0, bad5 = 0, bad6 = 0;
    int first_done = -1;
    logic [NC-1:0] exp_sig, held;
    @(negedge clk);
    pat_total = PW'(t_pat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= done_t; t++) begin
      bit e_load, e_capt, e_flush, e_done;
      e_load = 0; e_capt = 0; e_flush = 0; e_done = 0;
      if (t_pat == 0)              e_done = 1;
      else if (t < t_pat * P) begin
        if ((t % P) < L) e_load = 1; else e_capt = 1;
      end else if (t < t_pat * P + L) e_flush = 1;
      else                          e_done = 1;
      if (scan_en !== (e_load | e_flush) || capture_en !== e_capt) bad2 = 1;
      if (done !== e_done) bad6 = 1;
      if (done === 1'b1 && first_done < 0) first_done = t;
      if (e_load) begin
        if (chain_si !== b_spread(g)) bad3 = 1;
        g = b_gen(g);
      end
      if (e_flush && (chain_si !== '0 || capture_en !== 1'b0)) bad5 = 1;
      start = (mid_start && t == 5 && t_pat > 0);
      if (chg_total && t == 3) pat_total = PW'($urandom_range(1, 40));
      if (t < done_t) @(negedge clk);
    end
    start = 1'b0;
    exp_sig = model_sig(t_pat);
    if (t_pat > 0) begin
      check(!bad2, "R2 shift/capture sequence", {63'd0, bad2}, 64'd0);
      check(!bad3, "R3 spread values on fill cycles", {63'd0, bad3}, 64'd0);
      check(!bad5, "R5 unload pass zero input", {63'd0, bad5}, 64'd0);
    end
    check(!bad6 && first_done == done_t, "R6 done cycle", 64'(first_done), 64'(done_t));
    if (t_pat == 0)
      check(signature === MINIT, "R9 zero-pattern signature", 64'(signature), 64'(MINIT));
    else if (mid_start)
      check(signature === exp_sig, "R8 signature with ignored start", 64'(signature), 64'(exp_sig));
    else if (chg_total)
      check(signature === exp_sig, "R10 signature with total changed", 64'(signature), 64'(exp_sig));
    else
      check(signature === exp_sig, "R4 signature", 64'(signature), 64'(exp_sig));
    held = signature;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      pat_total = PW'($urandom_range(0, 60));
    end
    check(done === 1'b1 && signature === held, "R7 hold after done", 64'(signature), 64'(held));
  endtask

  initial begin
    void'($urandom(32'd553));
    repeat (3) @(negedge clk);
    check(scan_en === 1'b0 && capture_en === 1'b0 && done === 1'b0 && signature === '0,
          "R1 reset state", {scan_en, capture_en, done, 39'd0, signature}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(scan_en === 1'b0 && done === 1'b0, "R1 idle after reset", {62'd0, scan_en, done}, 64'd0);
    run_case(0, 0, 0);
    run_case(1, 0, 0);
    run_case(2, 0, 0);
    run_case(3, 1, 0);
    run_case(4, 0, 1);
    for (int r = 0; r < 4; r++)
      run_case(int'($urandom_range(1, 10)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    run_case(0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule